// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block collects up to 64 interrupt sources and presents one of them to a processor. Software sets it up through a small 32-bit register window. Each source carries three settings: an enable bit, a trigger style and a priority level. The trigger style is either level-following or rising-edge-latched. From the sources that are both pending and enabled, the controller picks the one with the highest priority and publishes its number in a vector register. It also drives a single request line to the CPU, but only while the global generation switch is on.

Reading the vector register acknowledges the presented source and starts its service. From then on, sources whose priority is equal to or lower than the serviced level are held back. A write of any value to the end-of-interrupt register finishes service, and the request line is recomputed on the following clock.

Edge latches are not cleared by end-of-interrupt. Software clears one by rewriting the source's setup word with the edge bit off and then on again. A one-bit-per-entry side table can be written through a packed address/data register and read back in two halves. A soft-reset command puts every register back to zero.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After a hardware reset, or after a write of 1 in bit 0 to offset 0x000, every register reads zero: generation enable, the enable sets, the setup words, the side table and the service state. The vector then reads 0xFFFFFFFF and `cpu_irq` is low. A write to offset 0x000 with bit 0 clear changes nothing.
- R2: A write to offset 0x020 sets the enable of source n (n = 0..31) for each data bit n that is 1. A write to offset 0x028 does the same for source 32+n. Bits written as 0 leave their sources as they were. Reads at these two offsets return the enable bits.
- R3: A write to offset 0x030 clears the enable of source n for each data bit n that is 1. A write to offset 0x038 does the same for source 32+n. Bits written as 0 have no effect.
- R4: A source with edge bit 0 is level-sensitive. It is pending exactly while its input is high, and `cpu_irq` follows one clock after the input.
- R5: A source with edge bit 1 latches a rising edge of its input. It stays pending after the input falls, and also after an end-of-interrupt write.
- R6: A setup write with the edge bit 0 clears that source's edge latch. While the edge bit is 0, no edge is captured.
- R7: `cpu_irq` stays low while the generation-enable bit (offset 0x008, bit 0) is 0.
- R8: A read at offset 0x010 returns the number of the pending, enabled, not-held-off source with the highest priority. Ties go to the lowest source number. When no source qualifies, the read returns 0xFFFFFFFF.
- R9: A vector read that returns a source number puts the controller in service at that source's priority. Sources at or below that priority are then held off, and a higher-priority source still raises `cpu_irq`.
- R10: A write of any data to offset 0x018 ends service. `cpu_irq` is recomputed on the next clock.
- R11: A write to offset 0x040 stores data bit 0 into side-table entry `wdata[13:8]`. Offset 0x048 reads entries 31..0 and offset 0x050 reads entries 63..32.
- R12: The setup word of source n is at offset 0x100 + 8n. Bits [3:0] hold the priority (higher wins) and bit 8 is the edge bit. All other bits are ignored on write and read back as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 10 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the clock after `bus_rd` |
| src_irq | input | 64 | Interrupt source inputs, synchronous to `clk` |
| cpu_irq | output | 1 | Registered request to the CPU |

## Verification
Internal state shows up at the ports quickly. A bad enable bit, edge latch or service level changes `cpu_irq` within one clock of the stimulus that exposes it. The same fault changes the vector read on the next access. A latch that fails to clear keeps `cpu_irq` high after the edge-bit toggle. A service level that is set wrongly either silences a source that should preempt or lets an equal-priority source request. The tests use ties and preemption so that a wrong winner appears as a different number in the vector read.

// File: rtl/vic_pkg.sv
package vic_pkg;
    localparam int VIC_AW = 10;
    localparam int VIC_DW = 32;

    localparam logic [VIC_AW-1:0] A_RST   = 10'h000;
    localparam logic [VIC_AW-1:0] A_GEN   = 10'h008;
    localparam logic [VIC_AW-1:0] A_VEC   = 10'h010;
    localparam logic [VIC_AW-1:0] A_EOI   = 10'h018;
    localparam logic [VIC_AW-1:0] A_ENL   = 10'h020;
    localparam logic [VIC_AW-1:0] A_ENH   = 10'h028;
    localparam logic [VIC_AW-1:0] A_DISL  = 10'h030;
    localparam logic [VIC_AW-1:0] A_DISH  = 10'h038;
    localparam logic [VIC_AW-1:0] A_TBLW  = 10'h040;
    localparam logic [VIC_AW-1:0] A_TBLL  = 10'h048;
    localparam logic [VIC_AW-1:0] A_TBLH  = 10'h050;
    localparam logic [VIC_AW-1:0] A_SETUP = 10'h100;

    localparam int EDGE_BIT = 8;
    localparam int TBL_SH   = 8;
endpackage

// File: rtl/vic_src_slice.sv
module vic_src_slice #(
    parameter int PW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_all,
    input  logic          set_en,
    input  logic          clr_en,
    input  logic          cfg_we,
    input  logic          cfg_edge,
    input  logic [PW-1:0] cfg_prio,
    input  logic          irq_in,
    output logic          en,
    output logic          edge_mode,
    output logic [PW-1:0] prio,
    output logic          pending
);
    typedef struct packed {
        logic          en;
        logic          edge_m;
        logic [PW-1:0] prio;
        logic          latch;
        logic          prev;
    } slice_t;

    slice_t q, d;

    always_comb begin
        d      = q;
        d.prev = irq_in;
        if (set_en) d.en = 1'b1;
        if (clr_en) d.en = 1'b0;
        if (!q.edge_m) begin
            d.latch = 1'b0;
        end else if (irq_in && !q.prev) begin
            d.latch = 1'b1;
        end
        if (cfg_we) begin
            d.edge_m = cfg_edge;
            d.prio   = cfg_prio;
            if (!cfg_edge) d.latch = 1'b0;
        end
        if (clr_all) d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign en        = q.en;
    assign edge_mode = q.edge_m;
    assign prio      = q.prio;
    assign pending   = q.en & (q.edge_m ? q.latch : irq_in);
endmodule

// File: rtl/vic_prio_pick.sv
module vic_prio_pick #(
    parameter int N   = 64,
    parameter int PW  = 4,
    parameter int IDW = 6
) (
    input  logic [N-1:0]    req,
    input  logic [N*PW-1:0] prio_flat,
    output logic            valid,
    output logic [IDW-1:0]  id,
    output logic [PW-1:0]   lvl
);
    always_comb begin
        valid = 1'b0;
        id    = '0;
        lvl   = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && (!valid || prio_flat[i*PW +: PW] > lvl)) begin
                valid = 1'b1;
                id    = IDW'(i);
                lvl   = prio_flat[i*PW +: PW];
            end
        end
    end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import vic_pkg::*;
#(
    parameter int NSRC      = 64,
    parameter int PW        = 4,
    parameter int TBL_DEPTH = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [VIC_AW-1:0] bus_addr,
    input  logic [VIC_DW-1:0] bus_wdata,
    output logic [VIC_DW-1:0] bus_rdata,
    input  logic [NSRC-1:0]   src_irq,
    output logic              cpu_irq
);
    localparam int IDW    = (NSRC > 1) ? $clog2(NSRC) : 1;
    localparam int TBL_AW = (TBL_DEPTH > 1) ? $clog2(TBL_DEPTH) : 1;
    localparam int CIW    = VIC_AW - 3;
    localparam logic [CIW-1:0] NSRC_C = CIW'(NSRC);

    typedef struct packed {
        logic                 gen_en;
        logic                 in_svc;
        logic [PW-1:0]        svc_lvl;
        logic                 win_valid;
        logic [IDW-1:0]       win_id;
        logic [PW-1:0]        win_lvl;
        logic                 irq;
        logic [VIC_DW-1:0]    rdata;
        logic [TBL_DEPTH-1:0] tbl;
    } ctrl_t;

    ctrl_t q, d;

    // bus decode
    logic              soft_rst;
    logic [VIC_AW-1:0] cfg_off;
    logic [CIW-1:0]    cfg_idx;
    logic [IDW-1:0]    cfg_sel;
    logic              cfg_hit;
    logic              cfg_wr;

    assign soft_rst = bus_wr && (bus_addr == A_RST) && bus_wdata[0];
    assign cfg_off  = bus_addr - A_SETUP;
    assign cfg_idx  = cfg_off[VIC_AW-1:3];
    assign cfg_sel  = cfg_idx[IDW-1:0];
    assign cfg_hit  = (bus_addr >= A_SETUP) && (cfg_off[2:0] == 3'b000) && (cfg_idx < NSRC_C);
    assign cfg_wr   = bus_wr && cfg_hit;

    // per-source state
    logic [NSRC-1:0]    en_vec;
    logic [NSRC-1:0]    edge_vec;
    logic [NSRC-1:0]    pend_vec;
    logic [NSRC*PW-1:0] prio_flat;
    logic [NSRC-1:0]    elig_vec;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        localparam int BITPOS = i % 32;
        localparam logic [VIC_AW-1:0] SET_A = (i < 32) ? A_ENL  : A_ENH;
        localparam logic [VIC_AW-1:0] CLR_A = (i < 32) ? A_DISL : A_DISH;

        logic set_i, clr_i, we_i;
        assign set_i = bus_wr && (bus_addr == SET_A) && bus_wdata[BITPOS];
        assign clr_i = bus_wr && (bus_addr == CLR_A) && bus_wdata[BITPOS];
        assign we_i  = cfg_wr && (cfg_sel == IDW'(i));

        vic_src_slice #(.PW(PW)) slice_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr_all  (soft_rst),
            .set_en   (set_i),
            .clr_en   (clr_i),
            .cfg_we   (we_i),
            .cfg_edge (bus_wdata[EDGE_BIT]),
            .cfg_prio (bus_wdata[PW-1:0]),
            .irq_in   (src_irq[i]),
            .en       (en_vec[i]),
            .edge_mode(edge_vec[i]),
            .prio     (prio_flat[i*PW +: PW]),
            .pending  (pend_vec[i])
        );

        // hold off sources at or below the serviced level
        assign elig_vec[i] = pend_vec[i] &&
                             (!q.in_svc || (prio_flat[i*PW +: PW] > q.svc_lvl));
    end

    logic           pick_valid;
    logic [IDW-1:0] pick_id;
    logic [PW-1:0]  pick_lvl;

    vic_prio_pick #(.N(NSRC), .PW(PW), .IDW(IDW)) pick_i (
        .req      (elig_vec),
        .prio_flat(prio_flat),
        .valid    (pick_valid),
        .id       (pick_id),
        .lvl      (pick_lvl)
    );

    logic [63:0]       en_ext;
    logic [63:0]       tbl_ext;
    logic [TBL_AW-1:0] tbl_addr;
    logic              gen_en_w;
    logic              in_svc_w;

    assign en_ext   = 64'(en_vec);
    assign tbl_ext  = 64'(q.tbl);
    assign tbl_addr = bus_wdata[TBL_SH +: TBL_AW];
    assign gen_en_w = q.gen_en;
    assign in_svc_w = q.in_svc;

    always_comb begin
        d           = q;
        d.win_valid = pick_valid;
        d.win_id    = pick_id;
        d.win_lvl   = pick_lvl;
        d.irq       = q.gen_en && pick_valid;

        if (bus_rd) begin
            d.rdata = '0;
            unique case (bus_addr)
                A_GEN:  d.rdata[0] = q.gen_en;
                A_VEC:  d.rdata    = q.win_valid ? VIC_DW'(q.win_id) : '1;
                A_ENL:  d.rdata    = en_ext[31:0];
                A_ENH:  d.rdata    = en_ext[63:32];
                A_TBLL: d.rdata    = tbl_ext[31:0];
                A_TBLH: d.rdata    = tbl_ext[63:32];
                default: begin
                    if (cfg_hit) begin
                        d.rdata[EDGE_BIT] = edge_vec[cfg_sel];
                        d.rdata[PW-1:0]   = prio_flat[cfg_sel*PW +: PW];
                    end
                end
            endcase
            if ((bus_addr == A_VEC) && q.win_valid) begin
                d.in_svc  = 1'b1;
                d.svc_lvl = q.win_lvl;
            end
        end

        if (bus_wr) begin
            if (bus_addr == A_GEN) d.gen_en = bus_wdata[0];
            if (bus_addr == A_TBLW) d.tbl[tbl_addr] = bus_wdata[0];
            if (bus_addr == A_EOI) begin
                d.in_svc  = 1'b0;
                d.svc_lvl = '0;
            end
        end

        if (soft_rst) d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign bus_rdata = q.rdata;
    assign cpu_irq   = q.irq;
endmodule

// File: rtl/vic_chk.sv
module vic_chk
    import vic_pkg::*;
#(
    parameter int NSRC = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [VIC_AW-1:0] bus_addr,
    input logic [VIC_DW-1:0] bus_wdata,
    input logic [VIC_DW-1:0] bus_rdata,
    input logic              cpu_irq,
    input logic              gen_en,
    input logic              in_svc,
    input logic [63:0]       en_ext
);
    // R7
    gen_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gen_en |=> !cpu_irq);

    // R1
    soft_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_RST && bus_wdata[0]) |=> (!gen_en && !in_svc && en_ext == 64'd0));

    // R10
    eoi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_EOI) |=> !in_svc);

    // R9
    svc_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && bus_addr == A_VEC) |=> (bus_rdata == '1 || in_svc));

    // R8
    vec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_VEC) |=> (bus_rdata == '1 || bus_rdata < NSRC));

    // R2
    en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_ENL) |=> ((en_ext[31:0] & $past(bus_wdata)) == $past(bus_wdata)));

    // R3
    dis_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_DISH) |=> ((en_ext[63:32] & $past(bus_wdata)) == 32'd0));
endmodule

bind irq_vector_ctrl vic_chk #(.NSRC(NSRC)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .cpu_irq  (cpu_irq),
    .gen_en   (gen_en_w),
    .in_svc   (in_svc_w),
    .en_ext   (en_ext)
);

// File: tb/irq_vector_ctrl_tb.sv
module irq_vector_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] src_irq = '0;
    logic        cpu_irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    localparam logic [31:0] NONE = 32'hFFFF_FFFF;

    always #5 clk = ~clk;

    irq_vector_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .src_irq(src_irq), .cpu_irq(cpu_irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [9:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        v = bus_rdata;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    function automatic logic [9:0] setup_a(input int n);
        return 10'(32'h100 + n * 8);
    endfunction

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 irq after reset", {31'd0, cpu_irq}, 32'd0);
        rd(10'h010, v); chk("R1 vector after reset", v, NONE);
        rd(10'h020, v); chk("R1 enable low after reset", v, 32'd0);
        rd(10'h008, v); chk("R1 gen enable after reset", v, 32'd0);
    endtask

    task automatic t_enable();
        logic [31:0] v;
        wr(10'h020, 32'h5);        rd(10'h020, v); chk("R2 set low", v, 32'h5);
        wr(10'h020, 32'h2);        rd(10'h020, v); chk("R2 zero bits keep", v, 32'h7);
        wr(10'h028, 32'h8000_0000); rd(10'h028, v); chk("R2 set high", v, 32'h8000_0000);
        wr(10'h030, 32'h4);        rd(10'h020, v); chk("R3 clear low", v, 32'h3);
        wr(10'h038, 32'h0);        rd(10'h028, v); chk("R3 zero bits no effect", v, 32'h8000_0000);
        wr(10'h038, 32'h8000_0000); rd(10'h028, v); chk("R3 clear high", v, 32'h0);
    endtask

    task automatic t_setup();
        logic [31:0] v;
        wr(setup_a(5), 32'h103);        rd(setup_a(5), v);  chk("R12 setup src5", v, 32'h103);
        wr(setup_a(63), 32'h00F);       rd(setup_a(63), v); chk("R12 setup src63", v, 32'h00F);
        wr(setup_a(6), 32'hFFFF_FFFF);  rd(setup_a(6), v);  chk("R12 spare bits ignored", v, 32'h10F);
        rd(setup_a(7), v); chk("R12 neighbour untouched", v, 32'h0);
    endtask

    task automatic t_soft_reset();
        logic [31:0] v;
        wr(10'h008, 32'h1);
        wr(10'h020, 32'h1);
        wr(10'h000, 32'h2);
        rd(10'h008, v); chk("R1 reset write bit0=0 ignored", v, 32'h1);
        wr(10'h000, 32'h1);
        rd(10'h008, v); chk("R1 soft reset gen", v, 32'h0);
        rd(10'h020, v); chk("R1 soft reset enables", v, 32'h0);
        rd(setup_a(5), v); chk("R1 soft reset setup", v, 32'h0);
    endtask

    task automatic t_level();
        logic [31:0] v;
        wr(setup_a(3), 32'h002);
        wr(10'h020, 32'h8);
        src_irq[3] = 1'b1;
        settle(); chk("R7 gated while gen off", {31'd0, cpu_irq}, 32'd0);
        wr(10'h008, 32'h1);
        settle(); chk("R4 level raises irq", {31'd0, cpu_irq}, 32'd1);
        @(negedge clk); src_irq[3] = 1'b0;
        @(negedge clk); chk("R4 irq follows one clock later", {31'd0, cpu_irq}, 32'd0);
        src_irq[3] = 1'b1;
        settle();
        rd(10'h010, v); chk("R8 vector level src", v, 32'd3);
        settle(); chk("R9 own level held off", {31'd0, cpu_irq}, 32'd0);
        wr(10'h018, 32'hDEAD_BEEF);
        chk("R10 not yet re-evaluated", {31'd0, cpu_irq}, 32'd0);
        @(negedge clk); chk("R10 irq next clock after eoi", {31'd0, cpu_irq}, 32'd1);
        src_irq[3] = 1'b0;
        wr(10'h000, 32'h1);
    endtask

    task automatic t_edge();
        logic [31:0] v;
        wr(setup_a(40), 32'h101);
        wr(10'h028, 32'h100);
        wr(10'h008, 32'h1);
        @(negedge clk); src_irq[40] = 1'b1;
        @(negedge clk); src_irq[40] = 1'b0;
        settle(); chk("R5 edge latched after input fell", {31'd0, cpu_irq}, 32'd1);
        rd(10'h010, v); chk("R5 vector edge src", v, 32'd40);
        wr(10'h018, 32'h0);
        settle(); chk("R5 latch survives eoi", {31'd0, cpu_irq}, 32'd1);
        wr(setup_a(40), 32'h001);
        @(negedge clk); src_irq[40] = 1'b1;
        @(negedge clk); src_irq[40] = 1'b0;
        wr(setup_a(40), 32'h101);
        settle(); chk("R6 toggle clears latch", {31'd0, cpu_irq}, 32'd0);
        rd(10'h010, v); chk("R6 no edge while bit off", v, NONE);
        wr(10'h000, 32'h1);
    endtask

    task automatic t_prio();
        logic [31:0] v;
        wr(setup_a(2), 32'h3);
        wr(setup_a(10), 32'h5);
        wr(setup_a(20), 32'h5);
        wr(setup_a(50), 32'h7);
        wr(10'h020, (32'h1 << 2) | (32'h1 << 10) | (32'h1 << 20));
        wr(10'h028, 32'h1 << 18);
        wr(10'h008, 32'h1);
        src_irq[2] = 1'b1; src_irq[10] = 1'b1; src_irq[20] = 1'b1;
        settle();
        rd(10'h010, v); chk("R8 tie lowest number", v, 32'd10);
        settle(); chk("R9 equal and lower held off", {31'd0, cpu_irq}, 32'd0);
        rd(10'h010, v); chk("R8 none while held off", v, NONE);
        src_irq[50] = 1'b1;
        settle(); chk("R9 higher preempts", {31'd0, cpu_irq}, 32'd1);
        rd(10'h010, v); chk("R8 highest priority wins", v, 32'd50);
        wr(10'h018, 32'h0);
        settle();
        rd(10'h010, v); chk("R10 after eoi highest again", v, 32'd50);
        wr(10'h018, 32'h0);
        src_irq[50] = 1'b0;
        settle();
        rd(10'h010, v); chk("R10 after eoi tie winner", v, 32'd10);
        src_irq = '0;
        wr(10'h000, 32'h1);
    endtask

    task automatic t_table();
        logic [31:0] v;
        wr(10'h040, (32'd37 << 8) | 32'h1);
        wr(10'h040, (32'd5 << 8) | 32'h1);
        rd(10'h048, v); chk("R11 table low half", v, 32'h20);
        rd(10'h050, v); chk("R11 table high half", v, 32'h20);
        wr(10'h040, (32'd5 << 8));
        rd(10'h048, v); chk("R11 table entry cleared", v, 32'h0);
        wr(10'h000, 32'h1);
        rd(10'h050, v); chk("R1 soft reset clears table", v, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_enable();
        t_setup();
        t_soft_reset();
        t_level();
        t_edge();
        t_prio();
        t_table();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule